// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller with Receive Trigger

This block holds the two byte FIFOs that sit between a UART's shift logic and the bus, together with the write-only control register that manages them. The receive side and the transmit side each have a 16-entry first-word-fall-through queue. The shift logic and the bus side use the push and pop ports. The current fill level and the full and empty flags of each queue are visible at the ports.

Software writes one control byte. Bit 0 is the master enable for both queues. Bits 1 and 2 request a one-shot flush of the receive queue or the transmit queue. Bits 7:6 choose how many received characters raise the receive interrupt. Any change of the enable bit empties both queues. Flush requests and trigger changes are accepted only when the written byte also has bit 0 set. Bits 5:3 have no function.

Top module: `ufifo_ctrl_top`

## Requirements
- R1: After reset, fifoEnable is 0, both levels are 0, both empty flags are 1, both full flags are 0, the overflow pulses are 0, rxTrigIrq is 0, and the trigger selection is 00.
- R2: Each queue returns bytes in push order. popData always shows the oldest entry. The level rises by one per accepted push and falls by one per accepted pop, one clock after the request.
- R3: A queue is full at 16 entries. A push to a full queue is dropped and leaves contents and level unchanged. The matching overflow output is 1 for exactly the one cycle after the dropped push.
- R4: A pop of an empty queue is ignored. The level stays 0 and empty stays 1.
- R5: A control write whose bit 0 differs from fifoEnable, in either direction, empties both queues on that clock. fifoEnable then takes the new value of bit 0.
- R6: A control write with bit 0 = 1 and bit 1 = 1 empties only the receive queue. The request does not persist, so later pushes are kept.
- R7: A control write with bit 0 = 1 and bit 2 = 1 empties only the transmit queue. The request does not persist.
- R8: A control write with bit 0 = 0 requests no flush through bits 1 and 2 and leaves the trigger selection unchanged. If fifoEnable was already 0, the queue levels are unchanged.
- R9: Control bits 7:6, taken from a write with bit 0 = 1, select the receive threshold: 00 = 1, 01 = 4, 10 = 8, 11 = 14 characters. rxTrigIrq is 1 exactly when rxLevel is greater than or equal to the threshold.
- R10: rxTrigIrq falls in the same cycle that rxLevel drops below the threshold, and rises in the same cycle that rxLevel reaches it.
- R11: When a flush and a push reach the same queue on the same clock, the flush wins. The queue ends empty and no overflow pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control byte: bit 0 enable, bit 1 receive flush, bit 2 transmit flush, bits 7:6 trigger select |
| rxPushEn | input | 1 | Push into receive queue |
| rxPushData | input | 8 | Byte to push into receive queue |
| rxPopEn | input | 1 | Pop from receive queue |
| rxPopData | output | 8 | Oldest byte in receive queue |
| rxLevel | output | 5 | Receive queue fill level |
| rxFull | output | 1 | Receive queue holds 16 entries |
| rxEmpty | output | 1 | Receive queue holds no entries |
| rxOverflow | output | 1 | One-cycle pulse after a dropped receive push |
| txPushEn | input | 1 | Push into transmit queue |
| txPushData | input | 8 | Byte to push into transmit queue |
| txPopEn | input | 1 | Pop from transmit queue |
| txPopData | output | 8 | Oldest byte in transmit queue |
| txLevel | output | 5 | Transmit queue fill level |
| txFull | output | 1 | Transmit queue holds 16 entries |
| txEmpty | output | 1 | Transmit queue holds no entries |
| txOverflow | output | 1 | One-cycle pulse after a dropped transmit push |
| fifoEnable | output | 1 | Current value of the enable bit |
| rxTrigIrq | output | 1 | Receive trigger interrupt |

## Verification
A corrupted pointer or count appears at the ports within one clock. It shows as a level that disagrees with the scoreboard queue, or as popData returning a byte out of order, and the bench catches it on the next pop or level sample. A wrong trigger selection, or a flush strobe that stays set, changes rxTrigIrq or the levels on the cycle after the control write. The bench checks every such write at that cycle, including writes made with the enable bit clear, which must change nothing.

// File: rtl/ufifo_pkg.sv
package ufifo_pkg;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  typedef struct packed {
    logic       rxFlush;
    logic       txFlush;
    logic [1:0] trigSel;
  } ctrlStrobes_t;

  function automatic logic [LVL_W-1:0] trigThresh(input logic [1:0] sel);
    case (sel)
      2'b00:   trigThresh = LVL_W'(1);
      2'b01:   trigThresh = LVL_W'(4);
      2'b10:   trigThresh = LVL_W'(8);
      default: trigThresh = LVL_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/ufifo_buf.sv
module ufifo_buf #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          pushEn,
  input  logic [W-1:0]  pushData,
  input  logic          popEn,
  output logic [W-1:0]  popData,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          overflow
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [LW-1:0] count;
  logic          doPush, doPop;

  assign full    = (count == LW'(DEPTH));
  assign empty   = (count == '0);
  assign level   = count;
  assign popData = mem[rdPtr];
  assign doPush  = pushEn && !full && !flush;
  assign doPop   = popEn && !empty && !flush;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    nextPtr = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= pushEn && full && !flush;
      if (flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (doPush) wrPtr <= nextPtr(wrPtr);
        if (doPop)  rdPtr <= nextPtr(rdPtr);
        case ({doPush, doPop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end
endmodule

// File: rtl/ufifo_cfg.sv
module ufifo_cfg
  import ufifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic              fifoEnable,
  output ctrlStrobes_t      strobes
);
  logic [1:0] trigSelQ;
  logic       toggle, accept;

  assign toggle = cfgWrEn && (cfgWrData[0] != fifoEnable);
  assign accept = cfgWrEn && cfgWrData[0];

  always_comb begin
    strobes.rxFlush = toggle || (accept && cfgWrData[1]);
    strobes.txFlush = toggle || (accept && cfgWrData[2]);
    strobes.trigSel = trigSelQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnable <= 1'b0;
      trigSelQ   <= 2'b00;
    end else if (cfgWrEn) begin
      fifoEnable <= cfgWrData[0];
      if (accept) trigSelQ <= cfgWrData[7:6];
    end
  end
endmodule

// File: rtl/ufifo_dp.sv
module ufifo_dp
  import ufifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              rxPushEn,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxPopEn,
  output logic [DATA_W-1:0] rxPopData,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              rxOverflow,
  input  logic              txPushEn,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txPopEn,
  output logic [DATA_W-1:0] txPopData,
  output logic [LVL_W-1:0]  txLevel,
  output logic              txFull,
  output logic              txEmpty,
  output logic              txOverflow,
  output logic              rxTrigIrq
);
  ufifo_buf #(.W(DATA_W), .DEPTH(DEPTH)) rxBuf_i (
    .clk(clk), .rstN(rstN), .flush(strobes.rxFlush),
    .pushEn(rxPushEn), .pushData(rxPushData), .popEn(rxPopEn),
    .popData(rxPopData), .level(rxLevel), .full(rxFull),
    .empty(rxEmpty), .overflow(rxOverflow)
  );

  ufifo_buf #(.W(DATA_W), .DEPTH(DEPTH)) txBuf_i (
    .clk(clk), .rstN(rstN), .flush(strobes.txFlush),
    .pushEn(txPushEn), .pushData(txPushData), .popEn(txPopEn),
    .popData(txPopData), .level(txLevel), .full(txFull),
    .empty(txEmpty), .overflow(txOverflow)
  );

  assign rxTrigIrq = (rxLevel >= trigThresh(strobes.trigSel));
endmodule

// File: rtl/ufifo_ctrl_top.sv
module ufifo_ctrl_top
  import ufifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              rxPushEn,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxPopEn,
  output logic [DATA_W-1:0] rxPopData,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              rxOverflow,
  input  logic              txPushEn,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txPopEn,
  output logic [DATA_W-1:0] txPopData,
  output logic [LVL_W-1:0]  txLevel,
  output logic              txFull,
  output logic              txEmpty,
  output logic              txOverflow,
  output logic              fifoEnable,
  output logic              rxTrigIrq
);
  ctrlStrobes_t strobes;

  ufifo_cfg cfg_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .fifoEnable(fifoEnable), .strobes(strobes)
  );

  ufifo_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rxPushEn(rxPushEn), .rxPushData(rxPushData), .rxPopEn(rxPopEn),
    .rxPopData(rxPopData), .rxLevel(rxLevel), .rxFull(rxFull),
    .rxEmpty(rxEmpty), .rxOverflow(rxOverflow),
    .txPushEn(txPushEn), .txPushData(txPushData), .txPopEn(txPopEn),
    .txPopData(txPopData), .txLevel(txLevel), .txFull(txFull),
    .txEmpty(txEmpty), .txOverflow(txOverflow),
    .rxTrigIrq(rxTrigIrq)
  );
endmodule

// File: rtl/ufifo_chk.sv
module ufifo_chk
  import ufifo_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [DATA_W-1:0] cfgWrData,
  input logic              rxPushEn,
  input logic              rxPopEn,
  input logic [LVL_W-1:0]  rxLevel,
  input logic              rxFull,
  input logic              rxEmpty,
  input logic              rxOverflow,
  input logic              txPushEn,
  input logic              txPopEn,
  input logic [LVL_W-1:0]  txLevel,
  input logic              txFull,
  input logic              txOverflow,
  input logic              fifoEnable,
  input logic              rxTrigIrq
);
  // R3: level never exceeds depth
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxLevel <= LVL_W'(DEPTH) && txLevel <= LVL_W'(DEPTH));

  // R3: overflow pulse only follows a push against a full queue
  p_rx_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow |-> $past(rxPushEn) && $past(rxFull));
  p_tx_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    txOverflow |-> $past(txPushEn) && $past(txFull));

  // R3: full stays full without pop or control write
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxFull && !rxPopEn && !cfgWrEn |=> rxFull);

  // R4: empty stays empty without push
  p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty && !rxPushEn |=> rxEmpty);

  // R5: enable toggle empties both queues
  p_toggle_flush_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && (cfgWrData[0] != fifoEnable) |=> rxLevel == '0 && txLevel == '0);

  // R8: disabled-write with no traffic leaves levels alone
  p_disabled_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && !cfgWrData[0] && !fifoEnable && !rxPushEn && !rxPopEn
      && !txPushEn && !txPopEn |=> $stable(rxLevel) && $stable(txLevel));

  // R9: interrupt implies data, and a full queue always interrupts
  p_irq_needs_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxTrigIrq |-> rxLevel != '0);
  p_irq_on_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> rxTrigIrq);
endmodule

bind ufifo_ctrl_top ufifo_chk chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .rxPushEn(rxPushEn), .rxPopEn(rxPopEn), .rxLevel(rxLevel),
  .rxFull(rxFull), .rxEmpty(rxEmpty), .rxOverflow(rxOverflow),
  .txPushEn(txPushEn), .txPopEn(txPopEn), .txLevel(txLevel),
  .txFull(txFull), .txOverflow(txOverflow),
  .fifoEnable(fifoEnable), .rxTrigIrq(rxTrigIrq)
);

// File: tb/ufifo_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module ufifo_ctrl_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic       rxPushEn = 1'b0, rxPopEn = 1'b0, txPushEn = 1'b0, txPopEn = 1'b0;
  logic [7:0] rxPushData = '0, txPushData = '0;
  logic [7:0] rxPopData, txPopData;
  logic [4:0] rxLevel, txLevel;
  logic       rxFull, rxEmpty, rxOverflow, txFull, txEmpty, txOverflow;
  logic       fifoEnable, rxTrigIrq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] rxQ[$];
  logic [7:0] txQ[$];

  always #4 clk = ~clk;

  ufifo_ctrl_top dut_i (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d;
    if (d[0] != fifoEnable) begin rxQ.delete(); txQ.delete(); end
    else if (d[0]) begin
      if (d[1]) rxQ.delete();
      if (d[2]) txQ.delete();
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d);
    @(negedge clk);
    rxPushEn = 1'b1; rxPushData = d;
    if (rxQ.size() < 16) rxQ.push_back(d);
    @(negedge clk);
    rxPushEn = 1'b0;
  endtask

  task automatic pushTx(input logic [7:0] d);
    @(negedge clk);
    txPushEn = 1'b1; txPushData = d;
    if (txQ.size() < 16) txQ.push_back(d);
    @(negedge clk);
    txPushEn = 1'b0;
  endtask

  // monitor side: compare the head of the scoreboard against the port
  task automatic popRx();
    @(negedge clk);
    if (rxQ.size() > 0) check("R2 rx order", rxPopData, rxQ.pop_front());
    rxPopEn = 1'b1;
    @(negedge clk);
    rxPopEn = 1'b0;
  endtask

  task automatic popTx();
    @(negedge clk);
    if (txQ.size() > 0) check("R2 tx order", txPopData, txQ.pop_front());
    txPopEn = 1'b1;
    @(negedge clk);
    txPopEn = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 enable", fifoEnable, 0);
    check("R1 rx level", rxLevel, 0);
    check("R1 rx empty", rxEmpty, 1);
    check("R1 tx empty", txEmpty, 1);
    check("R1 irq", rxTrigIrq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", rxLevel + txLevel + rxFull + txFull, 0);

    cfgWrite(8'h01);
    check("R5 enable set", fifoEnable, 1);

    for (int i = 0; i < 5; i++) pushRx(8'h10 + 8'(i));
    for (int i = 0; i < 3; i++) pushTx(8'hA0 + 8'(i));
    check("R2 rx level", rxLevel, 5);
    check("R2 tx level", txLevel, 3);
    check("R9 sel00 irq", rxTrigIrq, 1);
    cfgWrite(8'h41);
    check("R9 sel01 irq", rxTrigIrq, 1);
    cfgWrite(8'h81);
    check("R9 sel10 irq", rxTrigIrq, 0);
    check("R6 no flush without bit1", rxLevel, 5);
    check("R7 no flush without bit2", txLevel, 3);

    while (rxQ.size() > 0) popRx();
    while (txQ.size() > 0) popTx();
    check("R2 rx drained", rxEmpty, 1);

    // R4 pop of empty queue
    popRx();
    check("R4 rx level", rxLevel, 0);
    check("R4 rx empty", rxEmpty, 1);

    // trigger 14 and fill
    cfgWrite(8'hC1);
    for (int i = 0; i < 13; i++) pushRx(8'h30 + 8'(i));
    check("R9 sel11 at 13", rxTrigIrq, 0);
    pushRx(8'h3D);
    check("R10 irq rises at 14", rxTrigIrq, 1);
    pushRx(8'h3E);
    pushRx(8'h3F);
    check("R3 full", rxFull, 1);
    @(negedge clk);
    rxPushEn = 1'b1; rxPushData = 8'hEE;
    @(negedge clk);
    rxPushEn = 1'b0;
    check("R3 overflow pulse", rxOverflow, 1);
    check("R3 level held", rxLevel, 16);
    @(negedge clk);
    check("R3 pulse one cycle", rxOverflow, 0);
    popRx();
    popRx();
    check("R10 irq at 14", rxTrigIrq, 1);
    popRx();
    check("R10 irq falls at 13", rxTrigIrq, 0);

    // R6 receive flush leaves transmit alone
    pushTx(8'h55);
    pushTx(8'h66);
    cfgWrite(8'hC3);
    check("R6 rx flushed", rxLevel, 0);
    check("R6 tx kept", txLevel, 2);
    pushRx(8'h77);
    check("R6 self-clear", rxLevel, 1);

    // R7 transmit flush leaves receive alone
    cfgWrite(8'hC5);
    check("R7 tx flushed", txLevel, 0);
    check("R7 rx kept", rxLevel, 1);
    pushTx(8'h88);
    check("R7 self-clear", txLevel, 1);

    // R11 flush and push together
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = 8'hC3;
    rxPushEn = 1'b1; rxPushData = 8'h99;
    rxQ.delete();
    @(negedge clk);
    cfgWrEn = 1'b0; rxPushEn = 1'b0;
    check("R11 flush wins", rxLevel, 0);
    check("R11 no overflow", rxOverflow, 0);

    // R5 disable transition flushes both
    pushRx(8'h11);
    cfgWrite(8'h00);
    check("R5 disable rx", rxLevel, 0);
    check("R5 disable tx", txLevel, 0);
    check("R5 enable cleared", fifoEnable, 0);

    // R8 writes while disabled change nothing
    pushRx(8'h21);
    pushRx(8'h22);
    pushTx(8'h23);
    cfgWrite(8'h06);
    check("R8 rx level", rxLevel, 2);
    check("R8 tx level", txLevel, 1);
    check("R8 trigger kept", rxTrigIrq, 0);
    popRx();
    popRx();
    popTx();

    // R5 re-enable flushes queued data
    pushRx(8'h31);
    pushTx(8'h32);
    cfgWrite(8'h01);
    check("R5 enable rx", rxLevel, 0);
    check("R5 enable tx", txLevel, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule